// File: doc/BRIEF.md
# Watch-Crystal Time-Base Prescaler

This block divides a 32768 Hz clock through a chain of fifteen binary stages. Every power-of-two rate from 16384 Hz down to 1 Hz is present. Four time-base interrupt request lines are taken from chosen stages. A single select input remaps three of those lines to slower or faster rates, while the first line always runs at 1 Hz.

A write strobe clears the six slowest stages, 32 Hz through 1 Hz, without disturbing the faster ones. A 4-bit combinational capture port shows either the 128–16 Hz group or the 8–1 Hz group of stages. A 512 Hz strobe with a selectable active width is also produced for sampling inputs.

The clock input is the 32768 Hz time base itself, so each clock edge advances the divider by one count. All state is reset synchronously.

Top module: `tbase_prescaler`

## Requirements
- R1: The divider state is a binary count that advances by one on every clock edge. Capture bit k of a group holds the stage of that group whose rate is the group's fastest rate divided by 2^k.
- R2: While reset is held and on its release, every stage is 0 except the 1 Hz stage, which is 1. With `cap_hi_sel`=0 the capture port reads 4'b1000, with `cap_hi_sel`=1 it reads 4'b0000, and `irq` and `strobe` are 0.
- R3: The first `irq[0]` (1 Hz) pulse occurs in the cycle after the 32768th clock edge following reset release.
- R4: Each `irq` bit is a one-cycle pulse. It is high in exactly the cycle in which its source stage goes from 0 to 1.
- R5: With `irq_sel`=0, `irq[1]`, `irq[2]` and `irq[3]` follow the 64 Hz, 32 Hz and 128 Hz stages. With `irq_sel`=1 they follow the 8 Hz, 16 Hz and 64 Hz stages. Counted from reset release, a stage of 2^L Hz first rises after 16384/2^L edges and then every 32768/2^L edges.
- R6: A clock edge with `clr_req`=1 clears the 32 Hz to 1 Hz stages, while the faster stages keep counting. This raises no interrupt pulse, so after a clear within the first 512 edges the next 1 Hz pulse comes at edge 16384.
- R7: With `cap_hi_sel`=1, `cap_data` bits 0..3 are the 128, 64, 32 and 16 Hz stages. With `cap_hi_sel`=0 they are the 8, 4, 2 and 1 Hz stages. The value is taken live from the stage registers, with no latency.
- R8: `strobe` rises in the cycle in which the 512 Hz stage rises, which is 32 edges after reset release and then every 64 edges. It stays high for 1 cycle with `strobe_long`=0 and for 2 cycles with `strobe_long`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz time-base clock |
| rst | input | 1 | Synchronous active-high system reset |
| irq_sel | input | 1 | Interrupt rate remap select |
| clr_req | input | 1 | Clear strobe for the 32 Hz to 1 Hz stages |
| cap_hi_sel | input | 1 | Capture group select: 1 = 128–16 Hz, 0 = 8–1 Hz |
| strobe_long | input | 1 | 512 Hz strobe width: 1 = two cycles, 0 = one cycle |
| cap_data | output | 4 | Live state of the selected stage group |
| irq | output | 4 | Time-base interrupt pulses, bit 0 = 1 Hz line |
| strobe | output | 1 | 512 Hz sampling strobe |

## Verification
The interrupt lines are exercised under both select settings over a window long enough to contain two pulses of the slowest remapped source. The first-pulse edge tells a correct stage tap from a neighbouring one, and the pulse count tells a one-cycle pulse from a level or a missed edge. The 1 Hz line is timed from reset release, both uninterrupted and after a mid-run partial clear. These two cases separate a correct preset of the 1 Hz stage and a correct clear boundary from an off-by-one stage mapping. The strobe is compared edge by edge under both width settings, and the capture port is read in both groups at known counts.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  localparam int TB_LINES = 4;
  localparam int NIB_W    = 4;

  // bit index of the stage running at 2^log2_hz Hz
  function automatic int stage_of(input int n_stages, input int log2_hz);
    return n_stages - 1 - log2_hz;
  endfunction
endpackage

// File: rtl/tbp_divider.sv
module tbp_divider #(
  parameter int STAGES     = 15,
  parameter int CLR_STAGES = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_req,
  output logic [STAGES-1:0] cnt,
  output logic [STAGES-1:0] cnt_nxt
);
  localparam int KEEP = STAGES - CLR_STAGES;
  localparam logic [STAGES-1:0] ONE    = {{(STAGES-1){1'b0}}, 1'b1};
  localparam logic [STAGES-1:0] PRESET = {1'b1, {(STAGES-1){1'b0}}};

  always_comb begin
    cnt_nxt = cnt + ONE;
    if (clr_req) cnt_nxt[STAGES-1:KEEP] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= PRESET;
    else     cnt <= cnt_nxt;
  end

  // R6
  clr_slow_chk: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> (cnt[STAGES-1:KEEP] == '0));

  // R1
  fast_step_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (cnt[KEEP-1:0] == $past(cnt[KEEP-1:0]) + 1'b1));
endmodule

// File: rtl/tbp_irq.sv
module tbp_irq
  import tbp_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                irq_sel,
  input  logic [STAGES-1:0]   cnt,
  input  logic [STAGES-1:0]   cnt_nxt,
  output logic [TB_LINES-1:0] irq
);
  // source stage per line for select = 0 and select = 1
  localparam int SRC_A [TB_LINES] = '{stage_of(STAGES, 0), stage_of(STAGES, 6),
                                      stage_of(STAGES, 5), stage_of(STAGES, 7)};
  localparam int SRC_B [TB_LINES] = '{stage_of(STAGES, 0), stage_of(STAGES, 3),
                                      stage_of(STAGES, 4), stage_of(STAGES, 6)};

  logic [STAGES-1:0]   rise;
  logic [TB_LINES-1:0] irq_d;

  assign rise = cnt_nxt & ~cnt;

  for (genvar i = 0; i < TB_LINES; i++) begin : g_line
    localparam int SA = SRC_A[i];
    localparam int SB = SRC_B[i];
    assign irq_d[i] = irq_sel ? rise[SB] : rise[SA];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= irq_d;
  end

  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    (|irq) |=> (irq == '0));

  // R4
  irq_src_high_chk: assert property (@(posedge clk) disable iff (rst)
    irq[0] |-> cnt[stage_of(STAGES, 0)]);
endmodule

// File: rtl/tbp_strobe.sv
module tbp_strobe
  import tbp_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int TAP    = stage_of(STAGES, 9)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_long,
  input  logic [STAGES-1:0] cnt_nxt,
  output logic              strobe
);
  localparam logic [TAP:0] FIRST  = {1'b1, {TAP{1'b0}}};
  localparam logic [TAP:0] SECOND = FIRST + 1'b1;

  logic strobe_d;

  assign strobe_d = (cnt_nxt[TAP:0] == FIRST) |
                    (strobe_long & (cnt_nxt[TAP:0] == SECOND));

  always_ff @(posedge clk) begin
    if (rst) strobe <= 1'b0;
    else     strobe <= strobe_d;
  end

  // R8
  short_width_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && !strobe_long && !$past(strobe)) |=> !strobe);

  // R8
  long_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(strobe) && strobe_long) |=> strobe);
endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler
  import tbp_pkg::*;
#(
  parameter int STAGES     = 15,
  parameter int CLR_STAGES = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                irq_sel,
  input  logic                clr_req,
  input  logic                cap_hi_sel,
  input  logic                strobe_long,
  output logic [NIB_W-1:0]    cap_data,
  output logic [TB_LINES-1:0] irq,
  output logic                strobe
);
  localparam int B_128 = stage_of(STAGES, 7);
  localparam int B_8   = stage_of(STAGES, 3);

  logic [STAGES-1:0] cnt;
  logic [STAGES-1:0] cnt_nxt;

  tbp_divider #(.STAGES(STAGES), .CLR_STAGES(CLR_STAGES)) u_div (
    .clk(clk), .rst(rst), .clr_req(clr_req), .cnt(cnt), .cnt_nxt(cnt_nxt)
  );

  tbp_irq #(.STAGES(STAGES)) u_irq (
    .clk(clk), .rst(rst), .irq_sel(irq_sel), .cnt(cnt), .cnt_nxt(cnt_nxt), .irq(irq)
  );

  tbp_strobe #(.STAGES(STAGES)) u_stb (
    .clk(clk), .rst(rst), .strobe_long(strobe_long), .cnt_nxt(cnt_nxt), .strobe(strobe)
  );

  assign cap_data = cap_hi_sel ? cnt[B_128 +: NIB_W] : cnt[B_8 +: NIB_W];

  // R6
  clr_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> !irq[0]);

  // R2
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (irq == '0) && !strobe);
endmodule

// File: tb/sim_tbase_prescaler.sv
`timescale 1ns/1ps
module sim_tbase_prescaler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       irq_sel = 1'b0;
  logic       clr_req = 1'b0;
  logic       cap_hi_sel = 1'b0;
  logic       strobe_long = 1'b0;
  logic [3:0] cap_data;
  logic [3:0] irq;
  logic       strobe;

  int n_tests = 0;
  int n_fail  = 0;
  int edge_n  = 0;

  always #2 clk = ~clk;

  tbase_prescaler u0 (
    .clk(clk), .rst(rst), .irq_sel(irq_sel), .clr_req(clr_req),
    .cap_hi_sel(cap_hi_sel), .strobe_long(strobe_long),
    .cap_data(cap_data), .irq(irq), .strobe(strobe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    edge_n++;
  endtask

  task automatic read_cap(input logic hi, output int val);
    cap_hi_sel = hi;
    #0.5;
    val = int'(cap_data);
  endtask

  // leaves time at a negedge; the next posedge is counting edge 1
  task automatic do_reset();
    rst = 1'b1;
    clr_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    edge_n = 0;
  endtask

  task automatic t_reset();
    int v;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 irq in reset", int'(irq), 0);
    chk("R2 strobe in reset", int'(strobe), 0);
    read_cap(1'b0, v); chk("R2 low group in reset", v, 8);
    read_cap(1'b1, v); chk("R2 high group in reset", v, 0);
    cap_hi_sel = 1'b0;
  endtask

  task automatic t_first_tb1();
    int first = -1;
    int v;
    irq_sel = 1'b0;
    do_reset();
    while (edge_n < 32770) begin
      step();
      if (irq[0] && first < 0) first = edge_n;
      if (edge_n == 1000) begin
        read_cap(1'b1, v); chk("R7 high group at count 1000", v, 7);
        read_cap(1'b0, v); chk("R1 low group at count 1000", v, 8);
      end
      if (edge_n == 32767) begin
        read_cap(1'b0, v); chk("R1 low group before wrap", v, 7);
      end
      if (edge_n == 32769) chk("R4 1 Hz pulse width", int'(irq[0]), 0);
    end
    chk("R3 first 1 Hz pulse edge", first, 32768);
  endtask

  task automatic t_rates(input logic sel);
    int bsel [4];
    int first [4];
    int second [4];
    int cnt [4];
    int endn = 6200;
    if (sel) bsel = '{14, 11, 10, 8};
    else     bsel = '{14, 8, 9, 7};
    for (int i = 0; i < 4; i++) begin first[i] = -1; second[i] = -1; cnt[i] = 0; end
    irq_sel = sel;
    do_reset();
    while (edge_n < endn) begin
      step();
      for (int i = 0; i < 4; i++) begin
        if (irq[i]) begin
          cnt[i]++;
          if (first[i] < 0) first[i] = edge_n;
          else if (second[i] < 0) second[i] = edge_n;
        end
      end
    end
    for (int i = 1; i < 4; i++) begin
      int h = 1 << bsel[i];
      int expc = (endn < h) ? 0 : (endn - h) / (2 * h) + 1;
      chk($sformatf("R5 sel=%0d line %0d first pulse", sel, i), first[i], h);
      chk($sformatf("R5 sel=%0d line %0d second pulse", sel, i), second[i], 3 * h);
      chk($sformatf("R4 sel=%0d line %0d pulse cycles", sel, i), cnt[i], expc);
    end
    chk($sformatf("R5 sel=%0d 1 Hz line quiet", sel), cnt[0], 0);
  endtask

  task automatic t_strobe(input logic lng);
    int bad = 0;
    int first_bad = -1;
    int exp_v;
    strobe_long = lng;
    irq_sel = 1'b0;
    do_reset();
    while (edge_n < 300) begin
      step();
      exp_v = ((edge_n % 64) == 32 || (lng && (edge_n % 64) == 33)) ? 1 : 0;
      if (int'(strobe) != exp_v) begin
        bad++;
        if (first_bad < 0) first_bad = edge_n;
      end
    end
    chk($sformatf("R8 strobe long=%0d mismatching cycles", lng), bad, 0);
    if (bad != 0) chk("R8 first mismatching edge", first_bad, -1);
    strobe_long = 1'b0;
  endtask

  task automatic t_partial_clear();
    int v;
    int first = -1;
    int p = 300;
    irq_sel = 1'b0;
    do_reset();
    while (edge_n < p - 1) step();
    read_cap(1'b0, v); chk("R6 low group before clear", v, 8);
    clr_req = 1'b1;
    step();
    clr_req = 1'b0;
    chk("R6 no pulse on clear", int'(irq), 0);
    read_cap(1'b0, v); chk("R6 low group after clear", v, 0);
    read_cap(1'b1, v); chk("R6 fast stages kept", v, 2);
    cap_hi_sel = 1'b0;
    while (edge_n < 16390) begin
      step();
      if (irq[0] && first < 0) first = edge_n;
    end
    chk("R6 1 Hz pulse after clear", first, 16384);
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_first_tb1();
    t_rates(1'b0);
    t_rates(1'b1);
    t_strobe(1'b0);
    t_strobe(1'b1);
    t_partial_clear();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule